// File: doc/BRIEF.md
# Bridge Configuration Space Register File

This block holds the configuration header of a root-port bridge (the Type 1 layout), together with two optional capability structures: a short subsystem-identity capability and a PCI Express capability. Configuration accesses arrive on a simple one-cycle request port. Each access carries a byte address, a size of 1, 2 or 4 bytes, write data, and a read or write strobe. Read data and an error flag come back registered on the next cycle.

Every dword has three per-bit attribute masks: read-only, read-write and write-one-to-clear. These masks decide both what a read shows and what a write can change. A sub-dword write only touches the byte lanes it covers. Identity values come from strap inputs. Two option inputs withdraw I/O forwarding and prefetchable forwarding, which turns the matching fields read-only. The two capabilities are placed and chained according to which of them are enabled.

Write-one-to-clear bits are set by the hardware that owns them, through an event port. The event port names a storage slot: slots 0 to 15 are header dwords 0 to 15, and slot 16+k is dword k of the PCI Express capability. The port sets only the bits that are write-one-to-clear in that slot.

Top module: `cfg_bridge_regs`

## Requirements
- R1: A read returns read-only bits with their fixed value and read-write or write-one-to-clear bits from storage. Bits with none of the three attributes read 0. Example: writing all ones to PCIe link control (capability dword 4) reads back 0x0000CEFB, and bit 31 of the PCIe capability's first dword is always 0.
- R2: A 1-byte or 2-byte read returns the dword shifted right by 8 times addr[1:0], masked to 8 or 16 bits, so a 2-byte read at offset 3 returns byte 3 alone. A 4-byte access ignores addr[1:0].
- R3: A size other than 1, 2 or 4 raises rsp_err on the cycle after the request, returns 0 on a read and changes nothing on a write. A legal access clears rsp_err.
- R4: A write changes only read-write bits inside its byte lanes. All other bits keep their value.
- R5: Writing 1 to a write-one-to-clear bit inside the lanes clears it, and writing 0 leaves it set. An event sets the write-one-to-clear bits of the named slot and has no effect on other bits. An event wins over a clear in the same cycle.
- R6: In command/status (0x04), bits 0, 1, 2, 6 and 8 are writable. Status bits 24 and 27 to 31 are write-one-to-clear. Status bit 20 (capability list) reads 1.
- R7: In the bus-number dword (0x18), bits 23:0 are writable and bits 31:24 read 0.
- R8: In the memory window (0x20) and prefetchable window (0x24), bits 31:20 and 15:4 are writable and bits 19:16 and 3:0 read 0. The prefetchable upper-address dwords (0x28, 0x2C) are fully writable.
- R9: After reset, dword 0x00 reads {device, vendor}, 0x08 reads {0x060400, revision}, 0x0C reads 0x00010010 (bridge header type, cache line size 0x10), and rsp_rdata and rsp_err are 0.
- R10: The first capability sits at 0x40, and the header pointer at 0x34 holds 0x40 (0 when neither capability is enabled). By default the identity capability (ID 0x0D, 2 dwords) comes first and the PCIe capability (ID 0x10, 15 dwords, capability register 0x0042) follows it directly. With PCIE_FIRST the order is swapped. A next pointer names the other capability only if that one sits at a higher offset; otherwise it is 0.
- R11: With opt_no_io, command bit 0 and I/O base/limit bits 15:0 (0x1C) read 0 and ignore writes, and so does the I/O upper dword (0x30). With opt_no_pref, the whole prefetchable window dword reads 0 and ignores writes. Stored values reappear when the option is dropped.
- R12: PCIe slot status bits 16 to 20 and 24 (capability dword 6) and root status bit 16 (capability dword 8) are write-one-to-clear. Bridge-control bit 26 (0x3C) is write-one-to-clear only when the PCIe capability is absent; otherwise it reads 0.
- R13: Reads outside the header and the enabled capabilities return 0. Writes there, and writes to the identity capability, change nothing.
- R14: Read data appears on the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| str_vendor | input | 16 | Vendor identity strap |
| str_device | input | 16 | Device identity strap |
| str_rev | input | 8 | Revision strap |
| str_subsys_en | input | 1 | Enables the subsystem-identity capability |
| str_subsys_vendor | input | 16 | Subsystem vendor strap |
| str_subsys_dev | input | 16 | Subsystem device strap |
| str_pcie_en | input | 1 | Enables the PCI Express capability |
| opt_no_io | input | 1 | Withdraws I/O forwarding |
| opt_no_pref | input | 1 | Withdraws prefetchable forwarding |
| req_addr | input | AW | Byte address of the access |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| evt_idx | input | 5 | Storage slot for an event |
| evt_set | input | 32 | Bits to set in that slot's write-one-to-clear field |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered size error |

## Verification
The assertions assume that a read and a write never arrive together. They also assume that straps and options change only between accesses, never in the same cycle as a request. The bench issues one request per task call, with a single strobe raised for one cycle on the falling edge. It changes straps and options only in idle cycles. Events are raised alone, except in the one scenario that checks an event colliding with a clear on the same dword.

// File: rtl/cfg_bridge_regs.sv
module cfg_bridge_regs #(
  parameter int AW = 12,
  parameter bit PCIE_FIRST = 1'b0,
  localparam int NDW = 31,
  localparam int SW = $clog2(NDW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   str_vendor,
  input  logic [15:0]   str_device,
  input  logic [7:0]    str_rev,
  input  logic          str_subsys_en,
  input  logic [15:0]   str_subsys_vendor,
  input  logic [15:0]   str_subsys_dev,
  input  logic          str_pcie_en,
  input  logic          opt_no_io,
  input  logic          opt_no_pref,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [31:0]   req_wdata,
  input  logic          req_rd,
  input  logic          req_wr,
  input  logic [SW-1:0] evt_idx,
  input  logic [31:0]   evt_set,
  output logic [31:0]   rsp_rdata,
  output logic          rsp_err
);
  localparam int DW = AW - 2;
  localparam logic [DW-1:0] HDR_N = DW'(16);
  localparam logic [DW-1:0] SS_N  = DW'(2);
  localparam logic [DW-1:0] PX_N  = DW'(15);

  typedef struct packed {
    logic [31:0] ro;
    logic [31:0] rw;
    logic [31:0] w1c;
  } attr_t;

  function automatic attr_t attr_of(input int i, input logic px, input logic nio, input logic npf);
    attr_t a;
    a = '0;
    case (i)
      0, 2, 4, 5, 14: a.ro = '1;
      1: begin
        a.rw  = 32'h0000_0147;
        a.ro  = px ? 32'h0010_0000 : 32'h06B0_02B8;
        a.w1c = 32'hF900_0000;
        if (nio) begin
          a.rw[0] = 1'b0;
          a.ro[0] = 1'b1;
        end
      end
      3: a.ro = px ? 32'hFFFF_00FF : 32'hFFFF_FFFF;
      6: begin
        a.rw = 32'h00FF_FFFF;
        a.ro = px ? 32'h0 : 32'hFF00_0000;
      end
      7: begin
        a.rw  = 32'h0000_F0F0;
        a.ro  = (px ? 32'h0 : 32'h06A0_0000) | 32'h0000_0F0F;
        a.w1c = 32'hF900_0000;
        if (nio) begin
          a.ro = a.ro | 32'h0000_FFFF;
          a.rw = a.rw & 32'hFFFF_0000;
        end
      end
      8: begin
        a.rw = 32'hFFF0_FFF0;
        a.ro = 32'h000F_000F;
      end
      9: begin
        a.rw = npf ? 32'h0 : 32'hFFF0_FFF0;
        a.ro = npf ? 32'hFFFF_FFFF : 32'h000F_000F;
      end
      10, 11: a.rw = '1;
      12: begin
        a.rw = nio ? 32'h0 : 32'hFFFF_FFFF;
        a.ro = nio ? 32'hFFFF_FFFF : 32'h0;
      end
      13: a.ro = 32'h0000_00FF;
      15: begin
        a.rw  = px ? 32'h004F_00FF : 32'h0B6F_00FF;
        a.ro  = px ? 32'h0000_FF00 : 32'h0080_FF00;
        a.w1c = px ? 32'h0 : 32'h0400_0000;
      end
      16: a.ro = 32'h7FFF_FFFF;
      17: a.ro = 32'h0000_803F;
      18: begin
        a.rw  = 32'h0000_7FFF;
        a.w1c = 32'h000F_0000;
        a.ro  = 32'h0030_0000;
      end
      19: a.ro = 32'hFF7B_FFFF;
      20: begin
        a.rw  = 32'h0000_CEFB;
        a.ro  = 32'h3FFF_0000;
        a.w1c = 32'hC000_0000;
      end
      21: a.ro = '1;
      22: begin
        a.rw  = 32'h0000_7FFF;
        a.w1c = 32'h011F_0000;
        a.ro  = 32'h00E0_0000;
      end
      23: begin
        a.rw = 32'h0000_001F;
        a.ro = 32'h0001_0000;
      end
      24: begin
        a.ro  = 32'h0002_FFFF;
        a.w1c = 32'h0001_0000;
      end
      25: a.ro = 32'h80FF_FFFF;
      26: a.rw = 32'h0000_F7FF;
      27: a.ro = 32'h81FF_FFFE;
      28: begin
        a.rw  = 32'h0000_FFFF;
        a.w1c = 32'h8020_0000;
        a.ro  = 32'h73DF_0000;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  logic [NDW-1:0][31:0] st, nx;
  attr_t at [NDW];

  logic [DW-1:0] dw, ss_dw, px_dw;
  logic [7:0]    cap_ptr, ss_next, px_next;
  logic          hit, ss_hit, ssi;
  logic [SW-1:0] sidx;
  logic [31:0]   rv, ssv, rdw, lm, wd, shaped;
  logic [4:0]    sh;
  logic          size_ok, wr_go;

  assign dw = req_addr[AW-1:2];

  always_comb begin
    if (PCIE_FIRST) begin
      px_dw = HDR_N;
      ss_dw = str_pcie_en ? HDR_N + PX_N : HDR_N;
    end else begin
      ss_dw = HDR_N;
      px_dw = str_subsys_en ? HDR_N + SS_N : HDR_N;
    end
  end

  assign cap_ptr = (str_subsys_en | str_pcie_en) ? {HDR_N[5:0], 2'b00} : 8'h00;
  assign ss_next = (str_pcie_en && px_dw > ss_dw) ? {px_dw[5:0], 2'b00} : 8'h00;
  assign px_next = (str_subsys_en && ss_dw > px_dw) ? {ss_dw[5:0], 2'b00} : 8'h00;

  always_comb begin
    for (int i = 0; i < NDW; i++) at[i] = attr_of(i, str_pcie_en, opt_no_io, opt_no_pref);
  end

  always_comb begin
    hit = 1'b0;
    ss_hit = 1'b0;
    ssi = 1'b0;
    sidx = '0;
    if (dw < HDR_N) begin
      hit = 1'b1;
      sidx = SW'(dw);
    end else if (str_subsys_en && dw >= ss_dw && dw < ss_dw + SS_N) begin
      ss_hit = 1'b1;
      ssi = (dw != ss_dw);
    end else if (str_pcie_en && dw >= px_dw && dw < px_dw + PX_N) begin
      hit = 1'b1;
      sidx = SW'(dw - px_dw) + SW'(16);
    end
  end

  always_comb begin
    case (sidx)
      SW'(0):  rv = {str_device, str_vendor};
      SW'(1):  rv = 32'h0010_0000;
      SW'(2):  rv = {24'h060400, str_rev};
      SW'(3):  rv = 32'h0001_0010;
      SW'(13): rv = {24'h0, cap_ptr};
      SW'(16): rv = {16'h0042, px_next, 8'h10};
      default: rv = 32'h0;
    endcase
  end

  assign ssv = ssi ? {str_subsys_dev, str_subsys_vendor} : {16'h0, ss_next, 8'h0D};

  assign rdw = hit    ? ((rv & at[sidx].ro) | (st[sidx] & (at[sidx].rw | at[sidx].w1c))) :
               ss_hit ? ssv : 32'h0;

  assign size_ok = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);
  assign sh      = (req_size == 3'd4) ? 5'd0 : {req_addr[1:0], 3'b000};
  assign lm      = (req_size == 3'd4) ? 32'hFFFF_FFFF :
                   (req_size == 3'd2) ? (32'h0000_FFFF << sh) : (32'h0000_00FF << sh);
  assign wd      = req_wdata << sh;
  assign shaped  = (req_size == 3'd4) ? rdw :
                   (rdw >> sh) & ((req_size == 3'd2) ? 32'h0000_FFFF : 32'h0000_00FF);
  assign wr_go   = req_wr & size_ok;

  always_comb begin
    nx = st;
    for (int i = 0; i < NDW; i++) begin
      if (wr_go && hit && sidx == SW'(i)) begin
        nx[i] = (st[i] & ~(at[i].rw & lm)) | (wd & at[i].rw & lm);
        nx[i] = nx[i] & ~(wd & at[i].w1c & lm);
      end
      if (evt_idx == SW'(i)) nx[i] = nx[i] | (evt_set & at[i].w1c);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= '0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      st      <= nx;
      rsp_err <= (req_rd | req_wr) & ~size_ok;
      if (req_rd) rsp_rdata <= size_ok ? shaped : 32'h0;
    end
  end

  p_rd_wr_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_rd && req_wr));

  p_bad_size_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && !(req_size inside {3'd1, 3'd2, 3'd4})) |=> rsp_err);

  p_good_size_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((req_rd || req_wr) && (req_size inside {3'd1, 3'd2, 3'd4})) |=> !rsp_err);

  p_bad_wr_nochg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !(req_size inside {3'd1, 3'd2, 3'd4}) && evt_set == 32'h0) |=> $stable(st));

  p_byte_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_size == 3'd1) |=> rsp_rdata[31:8] == 24'h0);

  p_half_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && req_size == 3'd2) |=> rsp_rdata[31:16] == 16'h0);

  p_unmapped_rd_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_rd && !hit && !ss_hit) |=> rsp_rdata == 32'h0);

  p_unmapped_wr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !hit && evt_set == 32'h0) |=> $stable(st));

  p_status_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_set == 32'h0) |=> ((st[1][31:24] & ~$past(st[1][31:24])) == 8'h0));

  p_rd_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !req_rd |=> $stable(rsp_rdata));
endmodule

// File: tb/sim_cfg_bridge_regs.sv
`timescale 1ns/1ps
module sim_cfg_bridge_regs;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] ven = 16'h1AB3, dev = 16'h5C21, ssv = 16'h4A5B, ssd = 16'h0C0D;
  logic [7:0]  rev = 8'h07;
  logic sub_en = 1'b1, px_en = 1'b1, no_io = 1'b0, no_pf = 1'b0;
  logic [11:0] addr = '0;
  logic [2:0]  size = 3'd4;
  logic [31:0] wdata = '0, eset = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [4:0]  eidx = '0;
  logic [31:0] d0, d1;
  logic e0, e1;
  logic [31:0] r0, r1;
  logic re;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  cfg_bridge_regs u0 (
    .clk(clk), .rst_n(rst_n), .str_vendor(ven), .str_device(dev), .str_rev(rev),
    .str_subsys_en(sub_en), .str_subsys_vendor(ssv), .str_subsys_dev(ssd),
    .str_pcie_en(px_en), .opt_no_io(no_io), .opt_no_pref(no_pf),
    .req_addr(addr), .req_size(size), .req_wdata(wdata), .req_rd(rd), .req_wr(wr),
    .evt_idx(eidx), .evt_set(eset), .rsp_rdata(d0), .rsp_err(e0));

  cfg_bridge_regs #(.PCIE_FIRST(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .str_vendor(ven), .str_device(dev), .str_rev(rev),
    .str_subsys_en(sub_en), .str_subsys_vendor(ssv), .str_subsys_dev(ssd),
    .str_pcie_en(px_en), .opt_no_io(no_io), .opt_no_pref(no_pf),
    .req_addr(addr), .req_size(size), .req_wdata(wdata), .req_rd(rd), .req_wr(wr),
    .evt_idx(eidx), .evt_set(eset), .rsp_rdata(d1), .rsp_err(e1));

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic rdq(input logic [11:0] a, input logic [2:0] s);
    @(negedge clk);
    addr = a; size = s; rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    r0 = d0; r1 = d1; re = e0;
  endtask

  task automatic wrq(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d,
                     input logic [4:0] ei = 5'd0, input logic [31:0] eb = 32'h0);
    @(negedge clk);
    addr = a; size = s; wdata = d; wr = 1'b1; eidx = ei; eset = eb;
    @(negedge clk);
    wr = 1'b0; eset = 32'h0;
    r0 = d0; re = e0;
  endtask

  task automatic evt(input logic [4:0] ei, input logic [31:0] eb);
    @(negedge clk);
    eidx = ei; eset = eb;
    @(negedge clk);
    eset = 32'h0;
  endtask

  task automatic t_reset;
    chk("R9 rdata at reset", d0, 32'h0);
    chk("R9 err at reset", {31'h0, e0}, 32'h0);
    rdq(12'h000, 3'd4); chk("R9 id dword", r0, 32'h5C21_1AB3);
    rdq(12'h004, 3'd4); chk("R6 status cap list", r0, 32'h0010_0000);
    rdq(12'h008, 3'd4); chk("R9 class/rev", r0, 32'h0604_0007);
    rdq(12'h00C, 3'd4); chk("R9 header type/cache line", r0, 32'h0001_0010);
  endtask

  task automatic t_caps;
    rdq(12'h034, 3'd1); chk("R10 cap ptr", r0, 32'h40); chk("R10 cap ptr swapped", r1, 32'h40);
    rdq(12'h040, 3'd4); chk("R10 ssid head", r0, 32'h0000_480D); chk("R10 pcie head first", r1, 32'h0042_7C10);
    rdq(12'h044, 3'd4); chk("R10 ssid ids", r0, 32'h0C0D_4A5B);
    rdq(12'h048, 3'd4); chk("R10 pcie head second", r0, 32'h0042_0010);
    rdq(12'h07C, 3'd4); chk("R10 ssid head last", r1, 32'h0000_000D);
    rdq(12'h080, 3'd4); chk("R10 ssid ids last", r1, 32'h0C0D_4A5B);
    @(negedge clk); px_en = 1'b0;
    rdq(12'h040, 3'd4); chk("R10 ssid alone next 0", r0, 32'h0000_000D);
    rdq(12'h048, 3'd4); chk("R13 pcie absent reads 0", r0, 32'h0);
    @(negedge clk); px_en = 1'b1; sub_en = 1'b0;
    rdq(12'h040, 3'd4); chk("R10 pcie alone", r0, 32'h0042_0010); chk("R10 pcie alone swapped", r1, 32'h0042_0010);
    @(negedge clk); px_en = 1'b0;
    rdq(12'h034, 3'd1); chk("R10 no caps ptr 0", r0, 32'h0);
    rdq(12'h040, 3'd4); chk("R13 no caps 0x40", r0, 32'h0);
    @(negedge clk); px_en = 1'b1; sub_en = 1'b1;
  endtask

  task automatic t_cmd;
    wrq(12'h004, 3'd4, 32'hFFFF_FFFF);
    rdq(12'h004, 3'd4); chk("R6 cmd writable bits", r0, 32'h0010_0147);
    wrq(12'h005, 3'd1, 32'h0);
    rdq(12'h004, 3'd4); chk("R4 byte1 lane only", r0, 32'h0010_0047);
    wrq(12'h004, 3'd1, 32'hB8);
    rdq(12'h004, 3'd4); chk("R4 non-rw bits ignored", r0, 32'h0010_0000);
    wrq(12'h004, 3'd1, 32'h45);
    rdq(12'h004, 3'd4); chk("R6 cmd byte write", r0, 32'h0010_0045);
  endtask

  task automatic t_bus;
    wrq(12'h018, 3'd4, 32'hFFFF_FFFF);
    rdq(12'h018, 3'd4); chk("R7 bus numbers", r0, 32'h00FF_FFFF);
    rdq(12'h01A, 3'd1); chk("R2 byte read offset 2", r0, 32'hFF);
    rdq(12'h01B, 3'd2); chk("R2 half read offset 3", r0, 32'h0);
    rdq(12'h019, 3'd2); chk("R2 half read offset 1", r0, 32'hFFFF);
    wrq(12'h019, 3'd1, 32'h12);
    rdq(12'h018, 3'd4); chk("R4 byte write offset 1", r0, 32'h00FF_12FF);
  endtask

  task automatic t_mem;
    wrq(12'h020, 3'd4, 32'hFFFF_FFFF);
    rdq(12'h020, 3'd4); chk("R8 memory window", r0, 32'hFFF0_FFF0);
    wrq(12'h024, 3'd4, 32'h1234_5678);
    rdq(12'h024, 3'd4); chk("R8 pref window", r0, 32'h1230_5670);
    wrq(12'h028, 3'd4, 32'hA5A5_5A5A);
    rdq(12'h028, 3'd4); chk("R8 pref upper base", r0, 32'hA5A5_5A5A);
    wrq(12'h02C, 3'd4, 32'h0F0F_F0F0);
    rdq(12'h02C, 3'd4); chk("R8 pref upper limit", r0, 32'h0F0F_F0F0);
    rdq(12'h021, 3'd4); chk("R2 dword read ignores low bits", r0, 32'hFFF0_FFF0);
    rdq(12'h023, 3'd1); chk("R2 byte 3", r0, 32'hFF);
    rdq(12'h022, 3'd1); chk("R2 byte 2", r0, 32'hF0);
  endtask

  task automatic t_err;
    rdq(12'h018, 3'd3); chk("R3 err on size 3", {31'h0, re}, 32'h1); chk("R3 data 0 on bad read", r0, 32'h0);
    wrq(12'h018, 3'd0, 32'h0); chk("R3 err on size 0 write", {31'h0, re}, 32'h1);
    rdq(12'h018, 3'd4); chk("R3 bad write no change", r0, 32'h00FF_12FF); chk("R3 err cleared", {31'h0, re}, 32'h0);
    rdq(12'h018, 3'd5); chk("R3 err on size 5", {31'h0, re}, 32'h1);
  endtask

  task automatic t_w1c;
    evt(5'd1, 32'hFFFF_FFFF);
    rdq(12'h004, 3'd4); chk("R5 event sets status errors", r0, 32'hF910_0045);
    wrq(12'h006, 3'd2, 32'h0100);
    rdq(12'h004, 3'd4); chk("R5 one clears", r0, 32'hF810_0045);
    wrq(12'h007, 3'd1, 32'h00);
    rdq(12'h004, 3'd4); chk("R5 zero keeps", r0, 32'hF810_0045);
    wrq(12'h007, 3'd1, 32'hF8, 5'd1, 32'h0800_0000);
    rdq(12'h004, 3'd4); chk("R5 event beats clear", r0, 32'h0810_0045);
    evt(5'd0, 32'hFFFF_FFFF);
    rdq(12'h000, 3'd4); chk("R5 event on non-w1c ignored", r0, 32'h5C21_1AB3);
  endtask

  task automatic t_pcie;
    evt(5'd22, 32'hFFFF_FFFF);
    rdq(12'h060, 3'd4); chk("R12 slot status set", r0, 32'h011F_0000);
    wrq(12'h062, 3'd1, 32'h08);
    rdq(12'h060, 3'd4); chk("R12 presence change clear", r0, 32'h0117_0000);
    evt(5'd24, 32'hFFFF_FFFF);
    rdq(12'h068, 3'd4); chk("R12 root PME set", r0, 32'h0001_0000);
    wrq(12'h06A, 3'd1, 32'h01);
    rdq(12'h068, 3'd4); chk("R12 root PME clear", r0, 32'h0);
    wrq(12'h058, 3'd4, 32'hFFFF_FFFF);
    rdq(12'h058, 3'd4); chk("R1 link control mask", r0, 32'h0000_CEFB);
    evt(5'd20, 32'hFFFF_FFFF);
    rdq(12'h058, 3'd4); chk("R1 link status w1c bits", r0, 32'hC000_CEFB);
    evt(5'd15, 32'hFFFF_FFFF);
    rdq(12'h03C, 3'd4); chk("R12 bridge bit 26 absent with pcie", r0, 32'h0);
    @(negedge clk); px_en = 1'b0;
    evt(5'd15, 32'hFFFF_FFFF);
    rdq(12'h03C, 3'd4); chk("R12 bridge bit 26 set", r0, 32'h0400_0000);
    wrq(12'h03F, 3'd1, 32'h04);
    rdq(12'h03C, 3'd4); chk("R12 bridge bit 26 clear", r0, 32'h0);
    @(negedge clk); px_en = 1'b1;
  endtask

  task automatic t_opts;
    wrq(12'h01C, 3'd4, 32'hFFFF_FFFF);
    rdq(12'h01C, 3'd4); chk("R11 io window baseline", r0, 32'h0000_F0F0);
    @(negedge clk); no_io = 1'b1;
    rdq(12'h01C, 3'd4); chk("R11 io window hidden", r0, 32'h0);
    wrq(12'h01C, 3'd4, 32'h0);
    wrq(12'h004, 3'd2, 32'h0);
    wrq(12'h004, 3'd1, 32'h01);
    rdq(12'h004, 3'd4); chk("R11 io enable locked", r0, 32'h0810_0000);
    wrq(12'h030, 3'd4, 32'hFFFF_FFFF);
    rdq(12'h030, 3'd4); chk("R11 io upper locked", r0, 32'h0);
    @(negedge clk); no_io = 1'b0;
    rdq(12'h01C, 3'd4); chk("R11 io window kept", r0, 32'h0000_F0F0);
    rdq(12'h004, 3'd4); chk("R11 io enable kept", r0, 32'h0810_0001);
    rdq(12'h030, 3'd4); chk("R11 io upper unwritten", r0, 32'h0);
    @(negedge clk); no_pf = 1'b1;
    rdq(12'h024, 3'd4); chk("R11 pref window hidden", r0, 32'h0);
    wrq(12'h024, 3'd4, 32'h0);
    wrq(12'h028, 3'd4, 32'h1111_1111);
    rdq(12'h028, 3'd4); chk("R11 pref upper still writable", r0, 32'h1111_1111);
    @(negedge clk); no_pf = 1'b0;
    rdq(12'h024, 3'd4); chk("R11 pref window kept", r0, 32'h1230_5670);
  endtask

  task automatic t_unmapped;
    rdq(12'h084, 3'd4); chk("R13 past pcie end", r0, 32'h0);
    rdq(12'h100, 3'd4); chk("R13 extended space", r0, 32'h0);
    rdq(12'hFFC, 3'd4); chk("R13 top of space", r0, 32'h0);
    wrq(12'h084, 3'd4, 32'hFFFF_FFFF);
    rdq(12'h084, 3'd4); chk("R13 unmapped write ignored", r0, 32'h0);
    wrq(12'h044, 3'd4, 32'h0);
    rdq(12'h044, 3'd4); chk("R13 ssid write ignored", r0, 32'h0C0D_4A5B);
    wrq(12'h018, 3'd4, 32'h0);
    chk("R14 rdata held over write", r0, 32'h0C0D_4A5B);
    rdq(12'h018, 3'd4); chk("R14 next read updates", r0, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_caps;
    t_cmd;
    t_bus;
    t_mem;
    t_err;
    t_w1c;
    t_pcie;
    t_opts;
    t_unmapped;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule